// File: doc/BRIEF.md
# Inter-Processor Link Integrity Monitor

This block watches the private full-duplex packet link between two redundant processors. On the transmit side it computes a 32-bit CRC over each outgoing packet body so that the sender can append it. On the receive side it checks every incoming packet for exact length and a correct CRC. It pulls the fields the peer reports out of each accepted packet: its count of consecutive bad packets, its firmware version and its 128-bit configuration hash.

Time is cut into windows by a 1 ms tick, and each processor sends one packet per window. Every window that ends without an accepted packet adds one to a consecutive-error counter, and any accepted packet clears it. The peer's own counter, carried in its packets, covers the other direction of the link. A start-up handshake compares the peer's version and hash with the local ones on the first accepted packet. Normal operation is granted only after that comparison passes and one more good packet has arrived. Any trip condition raises a safe-state request that holds until reset.

Top module: `ipl_link_monitor`

## Requirements
- R1: The transmit CRC uses the reflected polynomial 0xEDB88320 (0x04C11DB7 bit-reversed), a starting value of all ones and a final inversion, and consumes one byte per clock. The start byte of a packet restarts the CRC. `tx_crc` and a one-cycle `tx_crc_vld` appear in the cycle after the end byte. The nine ASCII bytes "123456789" give 0xCBF43926.
- R2: A received packet is accepted only if it runs from a byte marked start to a byte marked end and is exactly 23 bytes long. The 23 bytes are: byte 0 the peer's error count, bytes 1-2 the version (most significant byte first), bytes 3-18 the hash (most significant byte first), and bytes 19-22 the CRC over bytes 0-18 (least significant byte first). The packet is rejected if the length differs or the CRC does not match.
- R3: Each tick ends a window. If no packet was accepted since the previous tick, the consecutive-error counter rises by one. Any accepted packet resets the counter to zero.
- R4: The safe-state request rises when the counter exceeds 20. Twenty empty windows in a row do not trip; the twenty-first does.
- R5: When an accepted packet reports an error count above 20, the safe-state request rises. A reported count of exactly 20 does not trip.
- R6: On the first accepted packet after reset, a peer version that differs from `local_ver` raises the safe-state request.
- R7: On the first accepted packet after reset, a peer hash that differs from `local_hash` in any bit raises the safe-state request.
- R8: `normal_en` rises only after the handshake comparison has passed and at least one further packet has been accepted. It stays high while no safe state is requested.
- R9: The safe-state request, once raised, holds until reset. While it is high, `link_ok` and `normal_en` stay low, whatever packets arrive.
- R10: After reset, `link_ok`, `normal_en`, `safe_req` and `tx_crc_vld` are low.
- R11: `link_ok` is high exactly when no safe state is requested, at least one packet has been accepted, the local counter is zero and the last reported peer count is zero.
- R12: Receive bytes that arrive without a preceding start mark are ignored, even if they form a packet with a valid CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1ms | input | 1 | One-cycle pulse marking the end of each 1 ms window |
| tx_valid | input | 1 | Outgoing byte present |
| tx_sop | input | 1 | Outgoing byte is the first of a packet |
| tx_eop | input | 1 | Outgoing byte is the last of a packet body |
| tx_data | input | 8 | Outgoing byte |
| tx_crc | output | 32 | CRC of the last outgoing packet body |
| tx_crc_vld | output | 1 | One-cycle pulse, `tx_crc` is fresh |
| rx_valid | input | 1 | Incoming byte present |
| rx_sop | input | 1 | Incoming byte is the first of a packet |
| rx_eop | input | 1 | Incoming byte is the last of a packet |
| rx_data | input | 8 | Incoming byte |
| local_ver | input | 16 | Local firmware version |
| local_hash | input | 128 | Local configuration hash |
| link_ok | output | 1 | Link currently healthy in both directions |
| normal_en | output | 1 | Normal operation allowed |
| safe_req | output | 1 | Latched safe-state request |

## Verification
The hardest condition to reach is the trip boundary: the counter has to climb through twenty windows with no accepted packet, and the request must appear only on the twenty-first. The stimulus first brings the link into normal operation. It then sends a run of bare ticks, breaks it partway with a good packet to show the count restarts, and only then lets the full run go to the limit. A second hard case is a packet that carries a correct CRC but is not a valid packet, because it is one byte short or has no start mark. The bench builds these with a genuine CRC, so that only the length and framing checks can reject them.

// File: rtl/ipl_pkg.sv
package ipl_pkg;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT      = 32'hFFFFFFFF;
    // register value left after a body plus its own CRC, least significant byte first
    localparam logic [31:0] CRC_RESIDUE   = 32'hDEBB20E3;

    typedef struct packed {
        logic       valid;
        logic       sop;
        logic       eop;
        logic [7:0] data;
    } byte_beat_t;

    typedef enum logic [1:0] {
        HS_SYNC     = 2'd0,
        HS_VERIFIED = 2'd1,
        HS_RUN      = 2'd2,
        HS_FAIL     = 2'd3
    } hs_state_t;

    function automatic logic [31:0] crc32_byte(input logic [31:0] c_in, input logic [7:0] b);
        logic [31:0] c;
        c = c_in ^ {24'h0, b};
        for (int k = 0; k < 8; k++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/ipl_tx_crc.sv
module ipl_tx_crc
    import ipl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  byte_beat_t  beat,
    output logic [31:0] crc_out,
    output logic        crc_vld
);
    logic [31:0] crc_q;
    logic [31:0] crc_base;
    logic [31:0] crc_nxt;

    always_comb begin
        crc_base = beat.sop ? CRC_INIT : crc_q;
        crc_nxt  = crc32_byte(crc_base, beat.data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q   <= CRC_INIT;
            crc_out <= '0;
            crc_vld <= 1'b0;
        end else begin
            crc_vld <= beat.valid && beat.eop;
            if (beat.valid) begin
                crc_q <= crc_nxt;
            end
            if (beat.valid && beat.eop) begin
                crc_out <= ~crc_nxt;
            end
        end
    end

    // R1
    tx_vld_follows_eop_chk: assert property (@(posedge clk) disable iff (rst)
        crc_vld |-> $past(beat.valid && beat.eop));

endmodule

// File: rtl/ipl_rx_check.sv
module ipl_rx_check
    import ipl_pkg::*;
#(
    parameter int VER_W  = 16,
    parameter int HASH_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  byte_beat_t        beat,
    output logic              pkt_good,
    output logic [7:0]        pkt_peer_cnt,
    output logic [VER_W-1:0]  pkt_ver,
    output logic [HASH_W-1:0] pkt_hash
);
    localparam int VER_B   = VER_W / 8;
    localparam int HASH_B  = HASH_W / 8;
    localparam int PKT_LEN = 1 + VER_B + HASH_B + 4;
    localparam int IDX_W   = $clog2(PKT_LEN + 2);
    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(PKT_LEN - 1);
    localparam logic [IDX_W-1:0] SAT_POS  = IDX_W'(PKT_LEN);
    localparam logic [IDX_W-1:0] VER_END  = IDX_W'(VER_B);
    localparam logic [IDX_W-1:0] HASH_END = IDX_W'(VER_B + HASH_B);

    logic              in_pkt;
    logic [IDX_W-1:0]  idx;
    logic [31:0]       crc_q;
    logic [31:0]       crc_nxt;
    logic [IDX_W-1:0]  pos;
    logic              accept;
    logic              end_ok;
    logic [7:0]        sh_peer;
    logic [VER_W-1:0]  sh_ver;
    logic [HASH_W-1:0] sh_hash;

    always_comb begin
        pos     = beat.sop ? '0 : idx;
        accept  = beat.valid && (beat.sop || in_pkt);
        crc_nxt = crc32_byte(beat.sop ? CRC_INIT : crc_q, beat.data);
        end_ok  = accept && beat.eop && (pos == LAST_POS) && (crc_nxt == CRC_RESIDUE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_pkt       <= 1'b0;
            idx          <= '0;
            crc_q        <= CRC_INIT;
            pkt_good     <= 1'b0;
            sh_peer      <= '0;
            sh_ver       <= '0;
            sh_hash      <= '0;
            pkt_peer_cnt <= '0;
            pkt_ver      <= '0;
            pkt_hash     <= '0;
        end else begin
            pkt_good <= end_ok;
            if (accept) begin
                crc_q  <= crc_nxt;
                idx    <= (pos == SAT_POS) ? pos : pos + 1'b1;
                in_pkt <= !beat.eop;
                if (pos == '0) begin
                    sh_peer <= beat.data;
                end else if (pos <= VER_END) begin
                    sh_ver <= (sh_ver << 8) | VER_W'(beat.data);
                end else if (pos <= HASH_END) begin
                    sh_hash <= (sh_hash << 8) | HASH_W'(beat.data);
                end
            end
            if (end_ok) begin
                pkt_peer_cnt <= sh_peer;
                pkt_ver      <= sh_ver;
                pkt_hash     <= sh_hash;
            end
        end
    end

    // R2
    rx_good_needs_eop_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_good |-> $past(beat.valid && beat.eop));

    // R2
    rx_fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pkt_good |-> $stable(pkt_ver) && $stable(pkt_hash));

endmodule

// File: rtl/ipl_health.sv
module ipl_health
    import ipl_pkg::*;
#(
    parameter int VER_W     = 16,
    parameter int HASH_W    = 128,
    parameter int ERR_LIMIT = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              pkt_good,
    input  logic [7:0]        pkt_peer_cnt,
    input  logic [VER_W-1:0]  pkt_ver,
    input  logic [HASH_W-1:0] pkt_hash,
    input  logic [VER_W-1:0]  local_ver,
    input  logic [HASH_W-1:0] local_hash,
    output logic              link_ok,
    output logic              normal_en,
    output logic              safe_req
);
    localparam int          CNT_W   = 8;
    localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(ERR_LIMIT);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] err_cnt;
    logic [CNT_W-1:0] peer_cnt;
    logic             seen;
    logic             ever_good;
    hs_state_t        hs;
    logic             id_match;

    assign id_match = (pkt_ver == local_ver) && (pkt_hash == local_hash);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_cnt   <= '0;
            peer_cnt  <= '0;
            seen      <= 1'b0;
            ever_good <= 1'b0;
            hs        <= HS_SYNC;
            safe_req  <= 1'b0;
        end else begin
            if (pkt_good) begin
                err_cnt <= '0;
            end else if (tick && !seen && err_cnt != CNT_MAX) begin
                err_cnt <= err_cnt + 1'b1;
            end
            if (tick) begin
                seen <= 1'b0;
            end else if (pkt_good) begin
                seen <= 1'b1;
            end
            if (pkt_good) begin
                peer_cnt  <= pkt_peer_cnt;
                ever_good <= 1'b1;
            end
            case (hs)
                HS_SYNC:     if (pkt_good) hs <= id_match ? HS_VERIFIED : HS_FAIL;
                HS_VERIFIED: if (pkt_good) hs <= HS_RUN;
                default:     hs <= hs;
            endcase
            safe_req <= safe_req || (err_cnt > LIMIT) || (peer_cnt > LIMIT) || (hs == HS_FAIL);
        end
    end

    assign link_ok   = !safe_req && ever_good && (err_cnt == '0) && (peer_cnt == '0);
    assign normal_en = (hs == HS_RUN) && !safe_req;

    // R9
    safe_latched_chk: assert property (@(posedge clk) disable iff (rst)
        safe_req |=> safe_req);

    // R4
    trip_after_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (err_cnt > LIMIT) |=> safe_req);

    // R8
    normal_after_packet_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(normal_en) |-> $past(pkt_good));

    // R6
    handshake_fail_trips_chk: assert property (@(posedge clk) disable iff (rst)
        (hs == HS_FAIL) |=> safe_req);

endmodule

// File: rtl/ipl_link_monitor.sv
module ipl_link_monitor
    import ipl_pkg::*;
#(
    parameter int VER_W     = 16,
    parameter int HASH_W    = 128,
    parameter int ERR_LIMIT = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1ms,
    input  logic              tx_valid,
    input  logic              tx_sop,
    input  logic              tx_eop,
    input  logic [7:0]        tx_data,
    output logic [31:0]       tx_crc,
    output logic              tx_crc_vld,
    input  logic              rx_valid,
    input  logic              rx_sop,
    input  logic              rx_eop,
    input  logic [7:0]        rx_data,
    input  logic [VER_W-1:0]  local_ver,
    input  logic [HASH_W-1:0] local_hash,
    output logic              link_ok,
    output logic              normal_en,
    output logic              safe_req
);
    byte_beat_t        tx_beat;
    byte_beat_t        rx_beat;
    logic              pkt_good;
    logic [7:0]        pkt_peer_cnt;
    logic [VER_W-1:0]  pkt_ver;
    logic [HASH_W-1:0] pkt_hash;

    assign tx_beat = '{valid: tx_valid, sop: tx_sop, eop: tx_eop, data: tx_data};
    assign rx_beat = '{valid: rx_valid, sop: rx_sop, eop: rx_eop, data: rx_data};

    ipl_tx_crc u_tx (
        .clk     (clk),
        .rst     (rst),
        .beat    (tx_beat),
        .crc_out (tx_crc),
        .crc_vld (tx_crc_vld)
    );

    ipl_rx_check #(.VER_W(VER_W), .HASH_W(HASH_W)) u_rx (
        .clk          (clk),
        .rst          (rst),
        .beat         (rx_beat),
        .pkt_good     (pkt_good),
        .pkt_peer_cnt (pkt_peer_cnt),
        .pkt_ver      (pkt_ver),
        .pkt_hash     (pkt_hash)
    );

    ipl_health #(.VER_W(VER_W), .HASH_W(HASH_W), .ERR_LIMIT(ERR_LIMIT)) u_health (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick_1ms),
        .pkt_good     (pkt_good),
        .pkt_peer_cnt (pkt_peer_cnt),
        .pkt_ver      (pkt_ver),
        .pkt_hash     (pkt_hash),
        .local_ver    (local_ver),
        .local_hash   (local_hash),
        .link_ok      (link_ok),
        .normal_en    (normal_en),
        .safe_req     (safe_req)
    );

    // R9
    no_normal_in_safe_chk: assert property (@(posedge clk) disable iff (rst)
        safe_req |-> !normal_en && !link_ok);

endmodule

// File: tb/sim_ipl_link_monitor.sv
`timescale 1ns/1ps
module sim_ipl_link_monitor;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_1ms = 1'b0;
    logic tx_valid = 1'b0, tx_sop = 1'b0, tx_eop = 1'b0;
    logic [7:0] tx_data = '0;
    logic [31:0] tx_crc;
    logic tx_crc_vld;
    logic rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
    logic [7:0] rx_data = '0;
    logic [15:0]  local_ver  = 16'h0207;
    logic [127:0] local_hash = 128'h0123456789ABCDEF_FEDCBA9876543210;
    logic link_ok, normal_en, safe_req;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    // reference model state
    int m_cnt, m_peer, m_hs;
    bit m_seen, m_ever, m_safe;

    always #2 clk = ~clk;

    ipl_link_monitor u0 (.*);

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [31:0] ref_crc(input logic [7:0] q[$]);
        logic [31:0] c = 32'hFFFFFFFF;
        foreach (q[i]) begin
            c ^= {24'h0, q[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        bit e_link, e_norm;
        e_link = !m_safe && m_ever && m_cnt == 0 && m_peer == 0;
        e_norm = (m_hs == 2) && !m_safe;
        check({req, " safe_req"},  {31'h0, safe_req},  {31'h0, m_safe});
        check({req, " link_ok"},   {31'h0, link_ok},   {31'h0, e_link});
        check({req, " normal_en"}, {31'h0, normal_en}, {31'h0, e_norm});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_cnt = 0; m_peer = 0; m_hs = 0;
        m_seen = 0; m_ever = 0; m_safe = 0;
        @(negedge clk);
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick_1ms = 1'b1;
        @(negedge clk);
        tick_1ms = 1'b0;
        repeat (3) @(negedge clk);
        if (!m_seen && m_cnt < 255) m_cnt++;
        m_seen = 0;
        if (m_cnt > 20) m_safe = 1;
    endtask

    // mode 0 good, 1 corrupt byte, 2 one byte short (valid CRC), 3 no start mark
    task automatic send_pkt(input logic [7:0] pc, input logic [15:0] v,
                            input logic [127:0] h, input int mode);
        logic [7:0] q[$];
        logic [31:0] c;
        q.push_back(pc);
        q.push_back(v[15:8]);
        q.push_back(v[7:0]);
        for (int i = 15; i >= 0; i--) q.push_back(h[i*8 +: 8]);
        if (mode == 2) q.delete(3);
        c = ref_crc(q);
        for (int i = 0; i < 4; i++) q.push_back(c[i*8 +: 8]);
        if (mode == 1) q[5] = q[5] ^ 8'h10;
        foreach (q[i]) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sop   = (i == 0) && (mode != 3);
            rx_eop   = (i == q.size() - 1);
            rx_data  = q[i];
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
        repeat (4) @(negedge clk);
        if (mode == 0) begin
            m_cnt = 0; m_seen = 1; m_peer = pc; m_ever = 1;
            if (m_hs == 0) m_hs = (v == local_ver && h == local_hash) ? 1 : 3;
            else if (m_hs == 1) m_hs = 2;
            if (m_peer > 20 || m_hs == 3) m_safe = 1;
        end
    endtask

    task automatic send_tx(input logic [7:0] q[$], input string req);
        foreach (q[i]) begin
            @(negedge clk);
            tx_valid = 1'b1;
            tx_sop   = (i == 0);
            tx_eop   = (i == q.size() - 1);
            tx_data  = q[i];
        end
        @(negedge clk);
        tx_valid = 1'b0; tx_sop = 1'b0; tx_eop = 1'b0;
        check({req, " crc_vld"}, {31'h0, tx_crc_vld}, 32'h1);
        check({req, " crc"}, tx_crc, ref_crc(q));
        @(negedge clk);
        check({req, " crc_vld pulse"}, {31'h0, tx_crc_vld}, 32'h0);
    endtask

    initial begin
        logic [7:0] s[$];
        do_reset();
        // R10 reset state
        check("R10 tx_crc_vld", {31'h0, tx_crc_vld}, 32'h0);
        check_state("R10");

        // R1 known check value and a second body
        s = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        send_tx(s, "R1 check-string");
        check("R1 known value", tx_crc, 32'hCBF43926);
        s = '{8'hA5, 8'h00, 8'hFF, 8'h5A};
        send_tx(s, "R1 second body");

        // R8 handshake pass, then one more packet
        send_pkt(8'd0, local_ver, local_hash, 0);
        check_state("R8 R11 after first packet");
        send_pkt(8'd0, local_ver, local_hash, 0);
        check_state("R8 after second packet");

        // R12 bytes without start mark ignored
        do_tick();
        send_pkt(8'd0, local_ver, local_hash, 3);
        do_tick();
        check_state("R12 no-sop packet");
        send_pkt(8'd0, local_ver, local_hash, 0);
        check_state("R3 good packet clears count");

        // R2 corrupt and short packets rejected
        do_tick();
        send_pkt(8'd0, local_ver, local_hash, 1);
        do_tick();
        check_state("R2 corrupt packet");
        send_pkt(8'd0, local_ver, local_hash, 0);
        do_tick();
        send_pkt(8'd0, local_ver, local_hash, 2);
        do_tick();
        check_state("R2 short packet");

        // R3 count restarts on a good packet mid-run
        for (int i = 0; i < 15; i++) do_tick();
        send_pkt(8'd0, local_ver, local_hash, 0);
        do_tick();
        for (int i = 0; i < 20; i++) do_tick();
        check_state("R3 R4 twenty empty windows");
        do_tick();
        check_state("R4 twenty-first window trips");

        // R9 latched despite good packets
        send_pkt(8'd0, local_ver, local_hash, 0);
        send_pkt(8'd0, local_ver, local_hash, 0);
        check_state("R9 latched");

        // R5 peer count boundary
        do_reset();
        send_pkt(8'd20, local_ver, local_hash, 0);
        check_state("R5 peer count 20");
        send_pkt(8'd21, local_ver, local_hash, 0);
        check_state("R5 peer count 21");

        // R6 version mismatch
        do_reset();
        send_pkt(8'd0, local_ver ^ 16'h0001, local_hash, 0);
        check_state("R6 version mismatch");
        send_pkt(8'd0, local_ver, local_hash, 0);
        check_state("R6 R9 stays tripped");

        // R7 hash mismatch in one bit
        do_reset();
        send_pkt(8'd0, local_ver, local_hash ^ (128'h1 << 77), 0);
        check_state("R7 hash mismatch");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule